// File: doc/BRIEF.md
# Address Range Breakpoint Comparator

This block watches the address of every transfer on a processor's local bus. When the address meets a programmed condition, it raises a trigger for a debug unit. Two full-width bound registers, low and high, define an unsigned address window. A control register holds a mode field that picks the condition: the address lies inside the window, the address lies outside it, or the address equals the low bound exactly. The control register also holds an enable bit.

A debug register write port loads the registers, selected by a 4-bit register number. A combinational read port returns the high bound and the control word. The low bound cannot be read back, and a read of it gives zero. A debug memory-access engine can replace the high bound with its own address through a dedicated strobe. Every later range decision then uses that replaced value. The trigger is a registered pulse, one clock after a qualifying transfer.

Top module: `addr_range_bkpt`

## Requirements
- R1: After reset the enable bit is 0, the mode field reads 2'b11 and `trig_o` is low. No trigger fires while the enable bit is 0, whatever the bounds and addresses.
- R2: With mode 2'b00 and the block enabled, a transfer triggers exactly when low <= address <= high, compared unsigned over all 32 bits.
- R3: With mode 2'b01 and the block enabled, a transfer triggers exactly when address < low or address > high.
- R4: With mode 2'b10 and the block enabled, a transfer triggers exactly when the address equals the low bound; the high bound plays no part.
- R5: With mode 2'b11 no transfer triggers.
- R6: Register writes are selected by number. 0xC loads the high bound, 0xD loads the low bound and 0x7 loads control, where bit 2 is enable and bits 1:0 are the mode. A write to any other number changes nothing.
- R7: The read port is combinational. Number 0xC returns the high bound, 0x7 returns the control word in bits 2:0 with zeros above, and 0xD and every other number return zero.
- R8: A debug memory-access strobe loads its address into the high bound at the next clock and wins over a same-cycle register write to 0xC. Later matches use the loaded value.
- R9: `trig_o` is high in the clock after a qualifying `xfer_valid_i` cycle and only then. Back-to-back qualifying transfers give back-to-back trigger cycles.
- R10: When low > high, mode 2'b00 never triggers and mode 2'b01 triggers on every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Debug register write strobe |
| reg_wr_num_i | input | 4 | Register number for the write |
| reg_wr_data_i | input | 32 | Write data |
| reg_rd_num_i | input | 4 | Register number for the read |
| reg_rd_data_o | output | 32 | Read data, combinational |
| mem_acc_wr_i | input | 1 | Debug memory-access strobe that overwrites the high bound |
| mem_acc_addr_i | input | 32 | Address the memory-access engine loads into the high bound |
| xfer_valid_i | input | 1 | Bus transfer valid |
| xfer_addr_i | input | 32 | Bus transfer address |
| trig_o | output | 1 | Registered breakpoint trigger pulse |

## Verification
Random bounds are drawn close together and far apart, so that both orderings of low and high occur. Probe addresses are taken at low, high, low-1, high+1 and at random; the two neighbours of each bound tell inclusive edges apart from exclusive ones. Each mode is tried with the same address set. This separates the inside and outside conditions from the exact-match condition, and shows that the undefined mode code stays silent. Directed sequences cover disabled operation, writes to unused numbers, the memory-access overwrite alone and racing a register write, and back-to-back transfers.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

   typedef enum logic [1:0] {
      MODE_INSIDE  = 2'b00,
      MODE_OUTSIDE = 2'b01,
      MODE_EXACT   = 2'b10,
      MODE_OFF     = 2'b11
   } bkpt_mode_e;

   typedef struct packed {
      logic       en;
      bkpt_mode_e mode;
   } bkpt_ctl_t;

   localparam int unsigned CTL_W = $bits(bkpt_ctl_t);

endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
   import bkpt_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned NUM_W    = 4,
   parameter logic [NUM_W-1:0] HI_NUM  = 4'hC,
   parameter logic [NUM_W-1:0] LO_NUM  = 4'hD,
   parameter logic [NUM_W-1:0] CTL_NUM = 4'h7,
   parameter bit DMA_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [NUM_W-1:0]  wr_num,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic [NUM_W-1:0]  rd_num,
   output logic [ADDR_W-1:0] rd_data,
   input  logic              acc_wr,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic [ADDR_W-1:0] lo_q,
   output logic [ADDR_W-1:0] hi_q,
   output bkpt_ctl_t         ctl_q
);

   logic wr_lo, wr_hi, wr_ctl;

   assign wr_lo  = wr_en && (wr_num == LO_NUM);
   assign wr_hi  = wr_en && (wr_num == HI_NUM);
   assign wr_ctl = wr_en && (wr_num == CTL_NUM);

   // bounds carry no reset value; the enable bit guards them
   always_ff @(posedge clk) begin
      if (wr_lo) lo_q <= wr_data;
   end

   generate
      if (DMA_WINS) begin : g_acc_first
         always_ff @(posedge clk) begin
            if (acc_wr)     hi_q <= acc_addr;
            else if (wr_hi) hi_q <= wr_data;
         end
      end else begin : g_reg_first
         always_ff @(posedge clk) begin
            if (wr_hi)       hi_q <= wr_data;
            else if (acc_wr) hi_q <= acc_addr;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q.en   <= 1'b0;
         ctl_q.mode <= MODE_OFF;
      end else if (wr_ctl) begin
         ctl_q <= bkpt_ctl_t'(wr_data[CTL_W-1:0]);
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_num == HI_NUM)
         rd_data = hi_q;
      else if (rd_num == CTL_NUM)
         rd_data[CTL_W-1:0] = ctl_q;
   end

endmodule

// File: rtl/bkpt_cmp.sv
module bkpt_cmp
   import bkpt_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] lo,
   input  logic [ADDR_W-1:0] hi,
   input  bkpt_mode_e        mode,
   output logic              hit
);

   logic ge_lo, le_hi, eq_lo, in_win;

   assign ge_lo  = (addr >= lo);
   assign le_hi  = (addr <= hi);
   assign eq_lo  = (addr == lo);
   assign in_win = ge_lo && le_hi;

   always_comb begin
      unique case (mode)
         MODE_INSIDE:  hit = in_win;
         MODE_OUTSIDE: hit = !in_win;
         MODE_EXACT:   hit = eq_lo;
         default:      hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/addr_range_bkpt.sv
module addr_range_bkpt
   import bkpt_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned NUM_W    = 4,
   parameter logic [NUM_W-1:0] HI_NUM  = 4'hC,
   parameter logic [NUM_W-1:0] LO_NUM  = 4'hD,
   parameter logic [NUM_W-1:0] CTL_NUM = 4'h7,
   parameter bit DMA_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_i,
   input  logic [NUM_W-1:0]  reg_wr_num_i,
   input  logic [ADDR_W-1:0] reg_wr_data_i,
   input  logic [NUM_W-1:0]  reg_rd_num_i,
   output logic [ADDR_W-1:0] reg_rd_data_o,
   input  logic              mem_acc_wr_i,
   input  logic [ADDR_W-1:0] mem_acc_addr_i,
   input  logic              xfer_valid_i,
   input  logic [ADDR_W-1:0] xfer_addr_i,
   output logic              trig_o
);

   initial begin
      assert (ADDR_W >= CTL_W) else $error("ADDR_W too narrow for control word");
      assert (HI_NUM != LO_NUM && HI_NUM != CTL_NUM && LO_NUM != CTL_NUM)
         else $error("register numbers must differ");
   end

   logic [ADDR_W-1:0] lo_q, hi_q;
   bkpt_ctl_t         ctl_q;
   logic              hit;
   logic              trig_q;

   bkpt_regs #(
      .ADDR_W(ADDR_W), .NUM_W(NUM_W), .HI_NUM(HI_NUM),
      .LO_NUM(LO_NUM), .CTL_NUM(CTL_NUM), .DMA_WINS(DMA_WINS)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr_i),
      .wr_num  (reg_wr_num_i),
      .wr_data (reg_wr_data_i),
      .rd_num  (reg_rd_num_i),
      .rd_data (reg_rd_data_o),
      .acc_wr  (mem_acc_wr_i),
      .acc_addr(mem_acc_addr_i),
      .lo_q    (lo_q),
      .hi_q    (hi_q),
      .ctl_q   (ctl_q)
   );

   bkpt_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .addr(xfer_addr_i),
      .lo  (lo_q),
      .hi  (hi_q),
      .mode(ctl_q.mode),
      .hit (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig_q <= 1'b0;
      else        trig_q <= xfer_valid_i && ctl_q.en && hit;
   end

   assign trig_o = trig_q;

endmodule

// File: rtl/bkpt_chk.sv
module bkpt_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned NUM_W  = 4,
   parameter logic [NUM_W-1:0] LO_NUM = 4'hD,
   parameter bit DMA_WINS = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              xfer_valid_i,
   input logic [ADDR_W-1:0] xfer_addr_i,
   input logic              mem_acc_wr_i,
   input logic [ADDR_W-1:0] mem_acc_addr_i,
   input logic [NUM_W-1:0]  reg_rd_num_i,
   input logic [ADDR_W-1:0] reg_rd_data_o,
   input logic              trig_o,
   input logic [ADDR_W-1:0] lo_q,
   input logic [ADDR_W-1:0] hi_q,
   input logic [2:0]        ctl_q
);

   assert_needs_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |-> $past(ctl_q[2]));

   assert_inside_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_o && $past(ctl_q[1:0]) == 2'b00) |->
      ($past(xfer_addr_i) >= $past(lo_q) && $past(xfer_addr_i) <= $past(hi_q)));

   assert_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_o && $past(ctl_q[1:0]) == 2'b10) |-> ($past(xfer_addr_i) == $past(lo_q)));

   assert_off_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |-> ($past(ctl_q[1:0]) != 2'b11));

   assert_lo_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_num_i == LO_NUM) |-> (reg_rd_data_o == '0));

   assert_acc_overwrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (DMA_WINS && mem_acc_wr_i) |=> (hi_q == $past(mem_acc_addr_i)));

   assert_pulse_after_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |-> $past(xfer_valid_i));

endmodule

bind addr_range_bkpt bkpt_chk #(
   .ADDR_W(ADDR_W), .NUM_W(NUM_W), .LO_NUM(LO_NUM), .DMA_WINS(DMA_WINS)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .xfer_valid_i  (xfer_valid_i),
   .xfer_addr_i   (xfer_addr_i),
   .mem_acc_wr_i  (mem_acc_wr_i),
   .mem_acc_addr_i(mem_acc_addr_i),
   .reg_rd_num_i  (reg_rd_num_i),
   .reg_rd_data_o (reg_rd_data_o),
   .trig_o        (trig_o),
   .lo_q          (lo_q),
   .hi_q          (hi_q),
   .ctl_q         (ctl_q)
);

// File: tb/addr_range_bkpt_tb.sv
module addr_range_bkpt_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_i = 1'b0;
   logic [3:0]  reg_wr_num_i = '0;
   logic [31:0] reg_wr_data_i = '0;
   logic [3:0]  reg_rd_num_i = '0;
   logic [31:0] reg_rd_data_o;
   logic        mem_acc_wr_i = 1'b0;
   logic [31:0] mem_acc_addr_i = '0;
   logic        xfer_valid_i = 1'b0;
   logic [31:0] xfer_addr_i = '0;
   logic        trig_o;

   int total = 0;
   int bad = 0;

   // bench model of the programmed state
   logic [31:0] m_lo = '0, m_hi = '0;
   logic [1:0]  m_mode = 2'b11;
   logic        m_en = 1'b0;

   always #5 clk = ~clk;

   addr_range_bkpt u_dut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_i(reg_wr_i), .reg_wr_num_i(reg_wr_num_i), .reg_wr_data_i(reg_wr_data_i),
      .reg_rd_num_i(reg_rd_num_i), .reg_rd_data_o(reg_rd_data_o),
      .mem_acc_wr_i(mem_acc_wr_i), .mem_acc_addr_i(mem_acc_addr_i),
      .xfer_valid_i(xfer_valid_i), .xfer_addr_i(xfer_addr_i),
      .trig_o(trig_o)
   );

   function automatic bit exp_hit(input logic [31:0] a);
      bit r;
      case (m_mode)
         2'b00:   r = (a >= m_lo) && (a <= m_hi);
         2'b01:   r = (a < m_lo) || (a > m_hi);
         2'b10:   r = (a == m_lo);
         default: r = 1'b0;
      endcase
      return r && m_en;
   endfunction

   function automatic string mode_req();
      case (m_mode)
         2'b00:   return "R2";
         2'b01:   return "R3";
         2'b10:   return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [3:0] num, input logic [31:0] data);
      @(negedge clk);
      reg_wr_i = 1'b1; reg_wr_num_i = num; reg_wr_data_i = data;
      @(negedge clk);
      reg_wr_i = 1'b0;
      if (num == 4'hC) m_hi = data;
      if (num == 4'hD) m_lo = data;
      if (num == 4'h7) begin m_en = data[2]; m_mode = data[1:0]; end
   endtask

   task automatic set_ctl(input logic en, input logic [1:0] mode);
      wr_reg(4'h7, {29'd0, en, mode});
   endtask

   task automatic xfer_chk(input logic [31:0] a, input string req);
      bit e;
      e = exp_hit(a);
      @(negedge clk);
      xfer_valid_i = 1'b1; xfer_addr_i = a;
      @(negedge clk);
      xfer_valid_i = 1'b0;
      chk(trig_o == e, req, {31'd0, trig_o}, {31'd0, e});
   endtask

   task automatic rd_chk(input logic [3:0] num, input logic [31:0] exp, input string req);
      reg_rd_num_i = num;
      #1;
      chk(reg_rd_data_o == exp, req, reg_rd_data_o, exp);
   endtask

   initial begin : watchdog
      #2_000_000;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [31:0] addrs [4];
      void'($urandom(32'd20240611));
      #22;
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(trig_o == 1'b0, "R1", {31'd0, trig_o}, 32'd0);
      rd_chk(4'h7, 32'h3, "R1");

      // R1 disabled: no trigger even with a window that matches
      wr_reg(4'hD, 32'h1000);
      wr_reg(4'hC, 32'h2000);
      set_ctl(1'b0, 2'b00);
      xfer_chk(32'h1800, "R1");
      set_ctl(1'b0, 2'b01);
      xfer_chk(32'h0, "R1");

      // R6 / R7 writes and reads by number
      rd_chk(4'hC, 32'h2000, "R7");
      rd_chk(4'hD, 32'h0, "R7");
      rd_chk(4'h7, 32'h1, "R7");
      rd_chk(4'h3, 32'h0, "R7");
      @(negedge clk);
      reg_wr_i = 1'b1; reg_wr_num_i = 4'h5; reg_wr_data_i = 32'hFFFF_FFFF;
      @(negedge clk);
      reg_wr_i = 1'b0;
      rd_chk(4'hC, 32'h2000, "R6");
      rd_chk(4'h7, 32'h1, "R6");
      set_ctl(1'b1, 2'b10);
      xfer_chk(32'h1000, "R6");   // low bound untouched by write to 0x5

      // R2 inclusive edges
      set_ctl(1'b1, 2'b00);
      xfer_chk(32'h1000, "R2");
      xfer_chk(32'h2000, "R2");
      xfer_chk(32'h0FFF, "R2");
      xfer_chk(32'h2001, "R2");
      // R3 edges
      set_ctl(1'b1, 2'b01);
      xfer_chk(32'h0FFF, "R3");
      xfer_chk(32'h1000, "R3");
      xfer_chk(32'hFFFF_FFFF, "R3");
      // R4 high bound ignored
      set_ctl(1'b1, 2'b10);
      xfer_chk(32'h2000, "R4");
      // R5
      set_ctl(1'b1, 2'b11);
      xfer_chk(32'h1000, "R5");

      // R8 memory-access overwrite of the high bound
      set_ctl(1'b1, 2'b00);
      @(negedge clk);
      mem_acc_wr_i = 1'b1; mem_acc_addr_i = 32'h3000;
      @(negedge clk);
      mem_acc_wr_i = 1'b0; m_hi = 32'h3000;
      rd_chk(4'hC, 32'h3000, "R8");
      xfer_chk(32'h2800, "R8");
      @(negedge clk);
      mem_acc_wr_i = 1'b1; mem_acc_addr_i = 32'h4000;
      reg_wr_i = 1'b1; reg_wr_num_i = 4'hC; reg_wr_data_i = 32'h1500;
      @(negedge clk);
      mem_acc_wr_i = 1'b0; reg_wr_i = 1'b0; m_hi = 32'h4000;
      rd_chk(4'hC, 32'h4000, "R8");

      // R9 back-to-back pulses and single-cycle width
      @(negedge clk);
      xfer_valid_i = 1'b1; xfer_addr_i = 32'h1100;
      @(negedge clk);
      chk(trig_o == 1'b1, "R9", {31'd0, trig_o}, 32'd1);
      xfer_addr_i = 32'h1200;
      @(negedge clk);
      xfer_valid_i = 1'b0;
      chk(trig_o == 1'b1, "R9", {31'd0, trig_o}, 32'd1);
      @(negedge clk);
      chk(trig_o == 1'b0, "R9", {31'd0, trig_o}, 32'd0);

      // R10 low above high
      wr_reg(4'hD, 32'h8000_0000);
      wr_reg(4'hC, 32'h7FFF_FFFF);
      set_ctl(1'b1, 2'b00);
      xfer_chk(32'h8000_0000, "R10");
      xfer_chk(32'h7FFF_FFFF, "R10");
      set_ctl(1'b1, 2'b01);
      xfer_chk(32'h8000_0000, "R10");
      xfer_chk(32'h1234_5678, "R10");

      // constrained random
      for (int i = 0; i < 400; i++) begin
         if (i % 8 == 0) begin
            logic [31:0] b;
            b = $urandom;
            wr_reg(4'hD, b);
            if ($urandom_range(0, 1) == 0)
               wr_reg(4'hC, b + $urandom_range(0, 64) - 8);
            else
               wr_reg(4'hC, $urandom);
            set_ctl($urandom_range(0, 7) != 0, 2'($urandom_range(0, 3)));
         end
         addrs[0] = m_lo; addrs[1] = m_hi;
         addrs[2] = m_lo - 1; addrs[3] = m_hi + 1;
         if ($urandom_range(0, 4) == 0)
            xfer_chk($urandom, m_en ? mode_req() : "R1");
         else
            xfer_chk(addrs[$urandom_range(0, 3)], m_en ? mode_req() : "R1");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule